// File: doc/BRIEF.md
# Hexagon Sector Finder for Space Vector Modulation

This block takes one stationary-frame voltage reference, given as a signed alpha component and a signed beta component in 1.15 fixed point, and reports which of the six 60-degree sectors of the inverter hexagon holds it. It needs no angle, no arctangent and no division. The signs of the two components pick a quadrant. A single comparison then splits that quadrant into its two sectors. The comparison is between the magnitude of beta scaled by 1/sqrt(3) and the magnitude of alpha.

A modulator front end uses the block once per switching period to choose which two active inverter states to apply. The caller presents a sample with `in_valid` high. Exactly one clock later, `out_valid` rises and `sector` carries the code for that sample. The code remains on `sector` until the next accepted sample.

Top module: `svm_sector_finder`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `sector` is 1 until the first sample is accepted.
- R2: `out_valid` equals `in_valid` from the previous clock edge. The `sector` value for a sample taken at one edge appears after that edge and is read before the next.
- R3: `sector` is a binary code from 1 to 6, where sector k covers angles from (k-1)*60 to k*60 degrees, measured counterclockwise from the positive alpha axis. The values 0 and 7 never appear.
- R4: The quadrant is chosen from the sign bits (bit 15) only, and a zero component counts as non-negative. Beta non-negative gives sectors 1 to 3, and beta negative gives sectors 4 to 6.
- R5: If alpha and beta are both non-negative, the result is 2 when scaled |beta| is strictly greater than alpha, and 1 otherwise (including equality).
- R6: If alpha is negative and beta is non-negative, the result is 2 when scaled |beta| is strictly greater than |alpha|, and 3 otherwise.
- R7: If alpha is non-negative and beta is negative, the result is 5 when scaled |beta| is strictly greater than alpha, and 6 otherwise.
- R8: If both are negative, the result is 5 when scaled |beta| is strictly greater than |alpha|, and 4 otherwise.
- R9: Absolute values saturate, so -32768 (0x8000) is used as 32767.
- R10: Scaled |beta| equals (|beta| * 0x49E7 + 0x4000) >> 15, which is the product by 1/sqrt(3) rounded to the nearest integer with ties rounded upward.
- R11: While `in_valid` is low, `sector` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies alpha and beta in this cycle |
| alpha | input | 16 | Signed 1.15 alpha component |
| beta | input | 16 | Signed 1.15 beta component |
| out_valid | output | 1 | Sector code for the previous cycle's sample is valid |
| sector | output | 3 | Sector code 1 to 6 |

## Verification
Both results are due one rising edge after the sample is accepted. `out_valid` and `sector` settle just after that edge. The bench sets inputs on a falling edge and reads both outputs on the next falling edge, which is half a period after the registering edge and before the following sample is taken. Hold behaviour is checked the same way, one falling edge after a cycle with `in_valid` low.

// File: rtl/svm_sector_pkg.sv
package svm_sector_pkg;

    typedef logic [2:0] sector_t;

    localparam sector_t SEC_1 = 3'd1;
    localparam sector_t SEC_2 = 3'd2;
    localparam sector_t SEC_3 = 3'd3;
    localparam sector_t SEC_4 = 3'd4;
    localparam sector_t SEC_5 = 3'd5;
    localparam sector_t SEC_6 = 3'd6;

    // quadrant named by the signs of (alpha, beta)
    typedef enum logic [1:0] {
        QUAD_PP = 2'b00,
        QUAD_NP = 2'b01,
        QUAD_PN = 2'b10,
        QUAD_NN = 2'b11
    } quad_e;

    typedef struct packed {
        logic    vld;
        sector_t sec;
    } finder_state_t;

    localparam finder_state_t FINDER_RESET = '{vld: 1'b0, sec: SEC_1};

endpackage

// File: rtl/svm_sat_abs.sv
module svm_sat_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0] value_i,
    output logic [W-2:0] mag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-2:0] MAG_MAX  = {(W-1){1'b1}};

    logic [W-1:0] negated;

    always_comb begin
        negated = ~value_i + 1'b1;
        if (value_i == MOST_NEG) begin
            mag_o = MAG_MAX;
        end else if (value_i[W-1]) begin
            mag_o = (W-1)'(negated);
        end else begin
            mag_o = (W-1)'(value_i);
        end
    end
endmodule

// File: rtl/svm_const_scale.sv
module svm_const_scale #(
    parameter int          W        = 15,
    parameter int          FRAC     = 15,
    parameter logic [W-1:0] COEF    = 15'h49E7,
    parameter bit          ROUND_EN = 1'b1
) (
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] scaled_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] product;
    logic [PW-1:0] biased;

    assign product = {{W{1'b0}}, mag_i} * {{W{1'b0}}, COEF};

    generate
        if (ROUND_EN) begin : g_round
            localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);
            assign biased = product + HALF;
        end else begin : g_trunc
            assign biased = product;
        end
    endgenerate

    assign scaled_o = W'(biased >> FRAC);
endmodule

// File: rtl/svm_sector_pick.sv
module svm_sector_pick
    import svm_sector_pkg::*;
(
    input  logic    alpha_neg_i,
    input  logic    beta_neg_i,
    input  logic    beta_wins_i,
    output sector_t sector_o
);
    quad_e quad;

    always_comb begin
        quad = quad_e'({beta_neg_i, alpha_neg_i});
        unique case (quad)
            QUAD_PP: sector_o = beta_wins_i ? SEC_2 : SEC_1;
            QUAD_NP: sector_o = beta_wins_i ? SEC_2 : SEC_3;
            QUAD_PN: sector_o = beta_wins_i ? SEC_5 : SEC_6;
            QUAD_NN: sector_o = beta_wins_i ? SEC_5 : SEC_4;
            default: sector_o = SEC_1;
        endcase
    end
endmodule

// File: rtl/svm_sector_finder.sv
module svm_sector_finder
    import svm_sector_pkg::*;
#(
    parameter int  DATA_W    = 16,
    parameter int  FRAC_W    = 15,
    parameter logic [DATA_W-2:0] INV_SQRT3 = 15'h49E7,
    parameter bit  ROUND_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] alpha,
    input  logic [DATA_W-1:0] beta,
    output logic              out_valid,
    output logic [2:0]        sector
);
    localparam int MAG_W = DATA_W - 1;

    logic [MAG_W-1:0] alpha_mag;
    logic [MAG_W-1:0] beta_mag;
    logic [MAG_W-1:0] beta_scaled;
    logic             beta_wins;
    sector_t          sec_pick;

    finder_state_t state_d, state_q;

    svm_sat_abs #(.W(DATA_W)) u_abs_alpha (
        .value_i (alpha),
        .mag_o   (alpha_mag)
    );

    svm_sat_abs #(.W(DATA_W)) u_abs_beta (
        .value_i (beta),
        .mag_o   (beta_mag)
    );

    svm_const_scale #(
        .W        (MAG_W),
        .FRAC     (FRAC_W),
        .COEF     (INV_SQRT3),
        .ROUND_EN (ROUND_EN)
    ) u_scale (
        .mag_i    (beta_mag),
        .scaled_o (beta_scaled)
    );

    assign beta_wins = beta_scaled > alpha_mag;

    svm_sector_pick u_pick (
        .alpha_neg_i (alpha[DATA_W-1]),
        .beta_neg_i  (beta[DATA_W-1]),
        .beta_wins_i (beta_wins),
        .sector_o    (sec_pick)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.sec = sec_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FINDER_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign sector    = state_q.sec;
endmodule

// File: rtl/svm_sector_finder_chk.sv
module svm_sector_finder_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] alpha,
    input logic [DATA_W-1:0] beta,
    input logic              out_valid,
    input logic [2:0]        sector
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector != 3'd0 && sector != 3'd7);

    // R4
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !beta[DATA_W-1]) |=> (sector inside {3'd1, 3'd2, 3'd3}));

    // R4
    lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && beta[DATA_W-1]) |=> (sector inside {3'd4, 3'd5, 3'd6}));

    // R5
    right_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !alpha[DATA_W-1]) |=> (sector inside {3'd1, 3'd2, 3'd5, 3'd6}));

    // R6
    left_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && alpha[DATA_W-1]) |=> (sector inside {3'd2, 3'd3, 3'd4, 3'd5}));

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sector));
endmodule

bind svm_sector_finder svm_sector_finder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .alpha     (alpha),
    .beta      (beta),
    .out_valid (out_valid),
    .sector    (sector)
);

// File: tb/svm_sector_finder_bench.sv
module svm_sector_finder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam int SWEEP = 211;
    localparam real PI = 3.14159265358979;

    // {alpha, beta, expected sector}
    localparam logic [34:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 3'd1},   // R4 R5 zeros
        {16'h49E6, 16'h7FFF, 3'd1},   // R5 equality
        {16'h49E5, 16'h7FFF, 3'd2},   // R5
        {16'h8000, 16'h0000, 3'd3},   // R6
        {16'hFFFF, 16'h0000, 3'd3},   // R6
        {16'h8000, 16'h7FFF, 3'd3},   // R9 alpha sat
        {16'hB61B, 16'h7FFF, 3'd2},   // R6
        {16'hB61A, 16'h7FFF, 3'd3},   // R6 equality
        {16'h49E6, 16'h8000, 3'd6},   // R7 R9 beta sat
        {16'h49E5, 16'h8000, 3'd5},   // R7
        {16'h0000, 16'hFFFF, 3'd5},   // R7 R10
        {16'hFFFF, 16'hFFFF, 3'd4},   // R8
        {16'hB61A, 16'h8000, 3'd4},   // R8
        {16'hB61B, 16'h8000, 3'd5},   // R8
        {16'h0000, 16'h0001, 3'd2},   // R10 round up
        {16'h0001, 16'h0001, 3'd1}    // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] alpha = '0;
    logic [15:0] beta = '0;
    logic        out_valid;
    logic [2:0]  sector;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svm_sector_finder u_svm_sector_finder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .alpha     (alpha),
        .beta      (beta),
        .out_valid (out_valid),
        .sector    (sector)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic v);
        alpha    = a;
        beta     = b;
        in_valid = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 sector in reset", int'(sector), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 sector after reset", int'(sector), 1);

        // table walk, back to back samples (R2 latency)
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][34:19], VEC[i][18:3], 1'b1);
            check("R2 out_valid", int'(out_valid), 1);
            check($sformatf("R3-table vec %0d", i), int'(sector), int'(VEC[i][2:0]));
        end

        // R11: idle cycles keep the last code while inputs change
        drive(16'h8000, 16'h8000, 1'b0);
        check("R2 out_valid drop", int'(out_valid), 0);
        check("R11 hold", int'(sector), 1);
        drive(16'h0000, 16'hFFFF, 1'b0);
        check("R11 hold again", int'(sector), 1);

        // R9 both saturated, then R4 lower half
        drive(16'h8000, 16'h8000, 1'b1);
        check("R9 both 0x8000", int'(sector), 4);

        // R3 angle sweep against arctangent reference
        for (int i = 0; i < SWEEP; i++) begin
            real ang = (2.0 * PI * i) / SWEEP + 0.013;
            real rem;
            int  a_i = $rtoi(29000.0 * $cos(ang));
            int  b_i = $rtoi(29000.0 * $sin(ang));
            real th = $atan2(real'(b_i), real'(a_i));
            int  exp_sec;
            if (th < 0.0) th = th + 2.0 * PI;
            exp_sec = $rtoi($floor(th / (PI / 3.0))) + 1;
            rem = th - (exp_sec - 1) * (PI / 3.0);
            drive(16'(a_i), 16'(b_i), 1'b1);
            if (rem > 0.01 && rem < (PI / 3.0) - 0.01 && exp_sec >= 1 && exp_sec <= 6) begin
                check($sformatf("R3 sweep step %0d", i), int'(sector), exp_sec);
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule